// File: doc/BRIEF.md
# Transmit Dominant Timeout Monitor

This block guards a CAN transmitter against a transmit data input that is stuck dominant (low). The input first passes through a two-flop synchronizer. While the device reports normal mode, a counter measures how long the synchronized input has been continuously dominant. When that run reaches a programmed number of clock cycles, the block switches the bus driver off.

A trip also latches three fault flags: a global interrupt flag, a CAN-category flag and a specific dominant-timeout flag. An active-low interrupt line follows those flags. The driver stays off for as long as the input remains dominant. It comes back after the first recessive sample. The flags stay set until the host clears them with a write-one-to-clear strobe.

The limit is a cycle-count parameter. At 40 MHz, the default of 140000 cycles corresponds to a nominal 3.5 ms timeout. The fault indication appears within a few clock cycles of detection, which is well inside a microsecond.

Top module: `txto_monitor`

## Requirements
- R1: After reset `drv_en` is 1, `flags` is 3'b000 and `irq_n` is 1.
- R2: With `mode_normal` high, if `tx_in` is low before rising edge 1 and stays low, `drv_en` is still 1 after edge TIMEOUT_CYC+1 and falls to 0 at edge TIMEOUT_CYC+2. This accounts for two synchronizer flops plus TIMEOUT_CYC counted samples.
- R3: A dominant run shorter than TIMEOUT_CYC samples never trips. A single recessive sample restarts the count from zero.
- R4: The count advances only while `mode_normal` is 1. Whenever `mode_normal` is 0, the count is cleared and no trip occurs. With the synchronized input already low, a trip comes exactly TIMEOUT_CYC edges after `mode_normal` rises.
- R5: A trip sets all three flags one edge after `drv_en` falls. The bit positions are: `flags[2]` global, `flags[1]` CAN category, `flags[0]` dominant timeout.
- R6: After a trip, `drv_en` stays 0 while `tx_in` stays low. It returns to 1 at the third rising edge after `tx_in` goes high. A new trip then needs a fresh run of TIMEOUT_CYC dominant samples.
- R7: A cycle with `clr_stb` high clears exactly the flags whose `clr_mask` bits are 1 (write-one-to-clear). `clr_mask` has no effect while `clr_stb` is 0.
- R8: `irq_n` is 0 exactly when at least one flag is set. It updates on the same edge as `flags`.
- R9: If a trip sets the flags on the same edge as a clear, the set wins and all three flags read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_normal | input | 1 | High while the device is in normal mode (synchronous to clk) |
| tx_in | input | 1 | Transmit data from the controller; 0 is dominant |
| clr_stb | input | 1 | Flag clear strobe |
| clr_mask | input | 3 | Flags to clear when `clr_stb` is high |
| drv_en | output | 1 | Bus driver enable, 0 while tripped |
| flags | output | 3 | Latched flags: [2] global, [1] category, [0] dominant timeout |
| irq_n | output | 1 | Active-low interrupt, low while any flag is set |

## Verification
The timing budgets are fixed:
- `tx_in` reaches the counter after two synchronizer edges.
- `drv_en` falls at edge TIMEOUT_CYC+2 after `tx_in` falls.
- `flags` and `irq_n` change one edge after `drv_en` falls.
- Recovery lands on the third edge after `tx_in` rises.
- A change of `mode_normal` acts on the very next edge.

The bench changes inputs and samples outputs only at falling edges. After k falling edges it therefore sees exactly the state left by k rising edges, and it checks the edge just before and the edge of each transition. The run-length and gap sweeps sum the driver-off cycles and compare them against max(0, L-TIMEOUT_CYC+1). This catches both early and late trips and both early and late releases.

// File: rtl/txto_pkg.sv
package txto_pkg;
  localparam int unsigned FLG_DOM    = 0;
  localparam int unsigned FLG_CAT    = 1;
  localparam int unsigned FLG_GLOBAL = 2;
  localparam int unsigned NUM_FLAGS  = 3;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/txto_sync.sv
module txto_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/txto_timer.sv
module txto_timer #(
  parameter int unsigned LIMIT = 140000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic line_rec,
  output logic drv_on,
  output logic trip_p
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      drv_on <= 1'b1;
      trip_p <= 1'b0;
    end else begin
      trip_p <= 1'b0;
      if (!drv_on) begin
        cnt <= '0;
        if (line_rec) drv_on <= 1'b1;
      end else if (!run_en || line_rec) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt    <= '0;
        drv_on <= 1'b0;
        trip_p <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2: the run counter never passes the limit
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));
  // R4: a trip only happens from normal mode
  p_trip_mode_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_on) |-> $past(run_en));
  // R6: release only after a recessive sample
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_on) |-> $past(line_rec));
  // R6: the driver stays off while the line is dominant
  p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!drv_on && !line_rec) |=> !drv_on);
endmodule

// File: rtl/txto_flags.sv
module txto_flags
  import txto_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_p,
  input  logic      clr_stb,
  input  flag_vec_t clr_mask,
  output flag_vec_t flags,
  output logic      irq_n
);
  flag_vec_t nxt;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    assign nxt[i] = set_p | (flags[i] & ~(clr_stb & clr_mask[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq_n <= 1'b1;
    end else begin
      flags <= nxt;
      irq_n <= ~|nxt;
    end
  end

  // R5: a trip pulse sets every flag
  p_set_all_r5: assert property (@(posedge clk) disable iff (rst)
    set_p |=> (&flags));
  // R7: strobed mask bits read zero afterwards when no trip competes
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_p) |=> ((flags & $past(clr_mask)) == '0));
  // R8: interrupt line tracks the flag bank
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq_n == ~|flags);
endmodule

// File: rtl/txto_monitor.sv
module txto_monitor
  import txto_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 140000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_normal,
  input  logic                 tx_in,
  input  logic                 clr_stb,
  input  logic [NUM_FLAGS-1:0] clr_mask,
  output logic                 drv_en,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq_n
);
  logic tx_s;
  logic trip_p;

  txto_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (tx_in),
    .dout (tx_s)
  );

  txto_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_en   (mode_normal),
    .line_rec (tx_s),
    .drv_on   (drv_en),
    .trip_p   (trip_p)
  );

  txto_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_p    (trip_p),
    .clr_stb  (clr_stb),
    .clr_mask (clr_mask),
    .flags    (flags),
    .irq_n    (irq_n)
  );

  // R5: driver shut-off is followed one edge later by all flags set
  p_trip_flags_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_en) |=> (&flags));
  // R9: a clear on the flag-setting edge loses to the trip
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv_en) && clr_stb) |=> (&flags));
endmodule

// File: tb/txto_monitor_test.sv
module txto_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_normal = 1'b1;
  logic tx_in = 1'b1;
  logic clr_stb = 1'b0;
  logic [2:0] clr_mask = 3'b000;
  logic drv_en;
  logic [2:0] flags;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  txto_monitor #(.TIMEOUT_CYC(LIM), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mode_normal(mode_normal), .tx_in(tx_in),
    .clr_stb(clr_stb), .clr_mask(clr_mask),
    .drv_en(drv_en), .flags(flags), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_stb = 1'b1; clr_mask = 3'b111;
    cyc(1);
    clr_stb = 1'b0; clr_mask = 3'b000;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int low;
    int exp_low;
    cyc(3);
    chk("R1 drv_en in reset", drv_en, 1);
    chk("R1 flags in reset", flags, 0);
    chk("R1 irq_n in reset", irq_n, 1);
    rst = 1'b0;
    cyc(4);
    chk("R1 drv_en idle", drv_en, 1);

    // R2 exact trip edge, R5/R8 flag edge
    tx_in = 1'b0;
    cyc(LIM + 1);
    chk("R2 drv_en one edge before trip", drv_en, 1);
    cyc(1);
    chk("R2 drv_en at trip edge", drv_en, 0);
    chk("R5 flags not yet set", flags, 0);
    cyc(1);
    chk("R5 flags after trip", flags, 3'b111);
    chk("R8 irq_n after trip", irq_n, 0);

    // R6 hold and release
    cyc(20);
    chk("R6 drv_en held off", drv_en, 0);
    tx_in = 1'b1;
    cyc(2);
    chk("R6 drv_en before release", drv_en, 0);
    cyc(1);
    chk("R6 drv_en released", drv_en, 1);
    chk("R7 flags latched after release", flags, 3'b111);

    // R7 write-one-to-clear
    clr_mask = 3'b111;
    cyc(1);
    chk("R7 mask without strobe", flags, 3'b111);
    clr_stb = 1'b1; clr_mask = 3'b000;
    cyc(1);
    chk("R7 strobe with empty mask", flags, 3'b111);
    clr_mask = 3'b010;
    cyc(1);
    clr_stb = 1'b0;
    chk("R7 clear category only", flags, 3'b101);
    chk("R8 irq_n with flags left", irq_n, 0);
    clr_stb = 1'b1; clr_mask = 3'b101;
    cyc(1);
    clr_stb = 1'b0; clr_mask = 3'b000;
    chk("R7 clear remaining", flags, 0);
    chk("R8 irq_n released", irq_n, 1);

    // R3/R6 run-length sweep
    for (int len = 1; len <= LIM + 4; len++) begin
      low = 0;
      tx_in = 1'b0;
      repeat (len) begin cyc(1); if (!drv_en) low++; end
      tx_in = 1'b1;
      repeat (6) begin cyc(1); if (!drv_en) low++; end
      exp_low = (len >= LIM) ? (len - LIM + 1) : 0;
      chk($sformatf("R3 R6 off cycles for run %0d", len), low, exp_low);
      chk($sformatf("R5 flags for run %0d", len), flags, (len >= LIM) ? 3'b111 : 3'b000);
      clear_all();
    end

    // R3 recessive gaps restart the count
    for (int gap = 1; gap <= 3; gap++) begin
      low = 0;
      tx_in = 1'b0;
      repeat (LIM - 1) begin cyc(1); if (!drv_en) low++; end
      tx_in = 1'b1;
      repeat (gap) begin cyc(1); if (!drv_en) low++; end
      tx_in = 1'b0;
      repeat (LIM - 1) begin cyc(1); if (!drv_en) low++; end
      tx_in = 1'b1;
      repeat (6) begin cyc(1); if (!drv_en) low++; end
      chk($sformatf("R3 no trip across gap %0d", gap), low, 0);
      chk($sformatf("R3 flags clear across gap %0d", gap), flags, 0);
    end
    low = 0;
    tx_in = 1'b0;
    repeat (LIM - 1) begin cyc(1); if (!drv_en) low++; end
    tx_in = 1'b1;
    repeat (1) begin cyc(1); if (!drv_en) low++; end
    tx_in = 1'b0;
    repeat (LIM) begin cyc(1); if (!drv_en) low++; end
    tx_in = 1'b1;
    repeat (6) begin cyc(1); if (!drv_en) low++; end
    chk("R3 full run after gap trips once", low, 1);
    clear_all();

    // R4 mode gating
    mode_normal = 1'b0;
    tx_in = 1'b0;
    cyc(3 * LIM);
    chk("R4 no trip outside normal", drv_en, 1);
    chk("R4 no flags outside normal", flags, 0);
    mode_normal = 1'b1;
    cyc(LIM - 1);
    chk("R4 edge before trip after mode entry", drv_en, 1);
    cyc(1);
    chk("R4 trip at limit after mode entry", drv_en, 0);
    tx_in = 1'b1;
    cyc(4);
    clear_all();
    mode_normal = 1'b0;
    tx_in = 1'b0;
    cyc(4);
    mode_normal = 1'b1;
    cyc(LIM - 1);
    mode_normal = 1'b0;
    cyc(1);
    mode_normal = 1'b1;
    cyc(LIM - 1);
    chk("R4 mode dip clears count", drv_en, 1);
    cyc(1);
    chk("R4 trip after full run past dip", drv_en, 0);
    tx_in = 1'b1;
    cyc(4);
    clear_all();
    chk("R7 flags cleared before R9 case", flags, 0);

    // R9 set beats clear
    tx_in = 1'b0;
    cyc(LIM + 2);
    chk("R9 drv_en tripped", drv_en, 0);
    clr_stb = 1'b1; clr_mask = 3'b111;
    cyc(1);
    clr_stb = 1'b0; clr_mask = 3'b000;
    chk("R9 set wins over clear", flags, 3'b111);
    chk("R9 irq_n low", irq_n, 0);
    tx_in = 1'b1;
    cyc(4);
    clear_all();
    chk("R8 irq_n after final clear", irq_n, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule